// File: doc/BRIEF.md
# Multi-Master Byte Transmit Arbiter

This block is the transmit half of a two-wire serial master that shares its bus with other masters. A byte is handed over with a load strobe. The block then presents its bits, most significant first, on an open-drain data line, which is modelled as an output enable that pulls the line low. It moves to the next bit only while the clock line is low. On every rising edge of the synchronized clock line it compares the bit it intends to send with the level actually on the line.

When the block sends a 1 and finds the line low, another master has won. The block stops driving the data line for the rest of the byte and sets a sticky lost flag. If the master is also able to act as a slave, it raises a request to switch into slave-receive mode in that same cycle. The block keeps counting clock pulses to the end of the byte, so the byte-complete pulse still appears on schedule. Arbitration is checked in every byte, not only in the address byte.

Top module: `arb_tx_unit`

## Requirements
- R1: After reset, sdaOe, arbLost, byteDone and slaveRxReq are all 0.
- R2: A loaded byte is sent most significant bit first. While bit i is presented, sdaOe is 1 when that bit is 0 (the line is pulled low) and sdaOe is 0 when that bit is 1 (the line is released).
- R3: sdaOe changes only while sclIn is low. The next bit appears on the clock cycle after a falling edge of sclIn that follows a sampled rising edge.
- R4: On the clock cycle after a rising edge of sclIn, if the block was releasing the line (bit 1) and sdaIn is 0, arbLost becomes 1.
- R5: A low level on sdaIn while sclIn is low, or while the block itself drives low, never sets arbLost.
- R6: After arbitration is lost, sdaOe stays 0 for every remaining bit of that byte.
- R7: byteDone is a single-cycle pulse on the clock cycle after the eighth falling edge of sclIn. The pulse appears whether or not arbitration was lost.
- R8: When arbitration is lost with slaveEn at 1, slaveRxReq rises in the same cycle as arbLost. With slaveEn at 0, slaveRxReq stays 0.
- R9: arbLost and slaveRxReq stay set across later bytes until a cycle with lostClear or startDet at 1 clears them. A later byte drives normally again.
- R10: A loadStb pulse while a byte is in progress is ignored, and the byte in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Synchronized clock-line level |
| sdaIn | input | 1 | Synchronized data-line level |
| loadStb | input | 1 | Start sending loadByte (accepted when idle) |
| loadByte | input | 8 | Byte to send |
| slaveEn | input | 1 | Master also supports slave operation |
| lostClear | input | 1 | Software clear of the lost flags |
| startDet | input | 1 | A START condition was seen on the bus |
| sdaOe | output | 1 | 1 pulls the data line low |
| arbLost | output | 1 | Sticky arbitration-lost flag |
| byteDone | output | 1 | One-cycle pulse at end of byte |
| slaveRxReq | output | 1 | Request to switch to slave-receive mode |

## Verification
On every cycle, the assertions check that sdaOe holds still through each clock-high phase. They check that a new loss is always preceded by a high clock with a low data line, and that the output is released once a loss is seen. They also check that the slave request rises only together with the lost flag, that byteDone is a single pulse following a falling edge, and that a clear with the clock low empties the flag. The bench scenarios are needed to show the actual bit order against a loaded value and the exact bit at which a given competitor wins. They also show that noise during the low phase is harmless, that the flags stay set over later bytes, and that a load in mid-byte is ignored.

// File: rtl/arb_tx_pkg.sv
package arb_tx_pkg;
  typedef struct packed {
    logic load;     // accept a new byte
    logic sample;   // compare bit with line (clock rising)
    logic advance;  // move to next bit (clock falling)
    logic finish;   // last bit completed (clock falling)
  } ctrl_strobes_t;
endpackage

// File: rtl/arb_tx_ctrl.sv
module arb_tx_ctrl
  import arb_tx_pkg::*;
#(
  parameter int BITS = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sclIn,
  input  logic          loadStb,
  output ctrl_strobes_t strb,
  output logic          busy
);
  localparam int CW = (BITS > 1) ? $clog2(BITS) : 1;
  localparam logic [CW-1:0] LAST = CW'(BITS - 1);

  logic          sclQ;
  logic          haveSample;
  logic [CW-1:0] bitCnt;
  logic          sclRise, sclFall, endBit;

  assign sclRise = sclIn & ~sclQ;
  assign sclFall = ~sclIn & sclQ;
  assign endBit  = busy & sclFall & haveSample;

  always_comb begin
    strb.load    = loadStb & ~busy;
    strb.sample  = busy & sclRise;
    strb.advance = endBit & (bitCnt != LAST);
    strb.finish  = endBit & (bitCnt == LAST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ       <= 1'b0;
      busy       <= 1'b0;
      haveSample <= 1'b0;
      bitCnt     <= '0;
    end else begin
      sclQ <= sclIn;
      if (strb.load) begin
        busy       <= 1'b1;
        bitCnt     <= '0;
        haveSample <= 1'b0;
      end else begin
        if (strb.finish) busy <= 1'b0;
        if (strb.advance) bitCnt <= bitCnt + 1'b1;
        if (strb.sample) haveSample <= 1'b1;
        else if (sclFall) haveSample <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/arb_tx_datapath.sv
module arb_tx_datapath
  import arb_tx_pkg::*;
#(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrl_strobes_t   strb,
  input  logic            busy,
  input  logic [BITS-1:0] loadByte,
  input  logic            sdaIn,
  input  logic            slaveEn,
  input  logic            lostClear,
  input  logic            startDet,
  output logic            sdaOe,
  output logic            arbLost,
  output logic            byteDone,
  output logic            slaveRxReq
);
  localparam int MSB = BITS - 1;

  logic [BITS-1:0] shiftReg;
  logic            lostByte;
  logic            lossNow;
  logic            clearReq;

  assign lossNow  = strb.sample & ~lostByte & shiftReg[MSB] & ~sdaIn;
  assign clearReq = lostClear | startDet;
  assign sdaOe    = busy & ~lostByte & ~shiftReg[MSB];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg   <= '1;
      lostByte   <= 1'b0;
      arbLost    <= 1'b0;
      slaveRxReq <= 1'b0;
      byteDone   <= 1'b0;
    end else begin
      byteDone <= strb.finish;
      if (strb.load) shiftReg <= loadByte;
      else if (strb.advance) shiftReg <= {shiftReg[MSB-1:0], 1'b1};

      if (strb.load) lostByte <= 1'b0;
      else if (lossNow) lostByte <= 1'b1;

      if (lossNow) arbLost <= 1'b1;
      else if (clearReq) arbLost <= 1'b0;

      if (lossNow && slaveEn) slaveRxReq <= 1'b1;
      else if (clearReq) slaveRxReq <= 1'b0;
    end
  end
endmodule

// File: rtl/arb_tx_unit.sv
module arb_tx_unit
  import arb_tx_pkg::*;
#(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            sclIn,
  input  logic            sdaIn,
  input  logic            loadStb,
  input  logic [BITS-1:0] loadByte,
  input  logic            slaveEn,
  input  logic            lostClear,
  input  logic            startDet,
  output logic            sdaOe,
  output logic            arbLost,
  output logic            byteDone,
  output logic            slaveRxReq
);
  ctrl_strobes_t strb;
  logic          busy;

  arb_tx_ctrl #(.BITS(BITS)) i_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .loadStb(loadStb),
    .strb(strb), .busy(busy)
  );

  arb_tx_datapath #(.BITS(BITS)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busy(busy),
    .loadByte(loadByte), .sdaIn(sdaIn), .slaveEn(slaveEn),
    .lostClear(lostClear), .startDet(startDet),
    .sdaOe(sdaOe), .arbLost(arbLost), .byteDone(byteDone),
    .slaveRxReq(slaveRxReq)
  );
endmodule

// File: rtl/arb_tx_checker.sv
module arb_tx_checker (
  input logic clk,
  input logic rstN,
  input logic sclIn,
  input logic sdaIn,
  input logic slaveEn,
  input logic lostClear,
  input logic startDet,
  input logic busy,
  input logic sdaOe,
  input logic arbLost,
  input logic byteDone,
  input logic slaveRxReq
);
  // R3: output frozen during a clock-high phase of an ongoing byte
  assert_oe_stable_high_R3: assert property (@(posedge clk) disable iff (!rstN)
    (sclIn && $past(sclIn) && busy && $past(busy)) |-> $stable(sdaOe));

  // R4: a new loss needs a high clock and a low data line on the previous cycle
  assert_loss_cause_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(arbLost) |-> ($past(sclIn) && !$past(sdaIn)));

  // R6: line released right after a loss
  assert_release_after_loss_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(arbLost) |-> !sdaOe);

  // R7: byteDone is one cycle wide and follows a falling clock edge
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    byteDone |=> !byteDone);
  assert_done_after_fall_R7: assert property (@(posedge clk) disable iff (!rstN)
    byteDone |-> !$past(sclIn));

  // R8: slave request only together with a loss, and always when enabled
  assert_slave_with_loss_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(slaveRxReq) |-> $rose(arbLost));
  assert_slave_when_enabled_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(arbLost) && $past(slaveEn)) |-> slaveRxReq);

  // R9: clear with clock low empties both flags
  assert_clear_flags_R9: assert property (@(posedge clk) disable iff (!rstN)
    ((lostClear || startDet) && !sclIn) |=> (!arbLost && !slaveRxReq));
endmodule

bind arb_tx_unit arb_tx_checker i_chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .slaveEn(slaveEn),
  .lostClear(lostClear), .startDet(startDet), .busy(busy), .sdaOe(sdaOe),
  .arbLost(arbLost), .byteDone(byteDone), .slaveRxReq(slaveRxReq)
);

// File: tb/test_arb_tx_unit.sv
module test_arb_tx_unit;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclIn = 1'b0;
  logic       loadStb = 1'b0;
  logic [7:0] loadByte = 8'h00;
  logic       slaveEn = 1'b0;
  logic       lostClear = 1'b0;
  logic       startDet = 1'b0;
  logic       otherPull = 1'b0;
  logic       sdaIn;
  logic       sdaOe, arbLost, byteDone, slaveRxReq;

  int checks = 0;
  int errors = 0;
  logic stickyLost = 1'b0;
  logic stickySlave = 1'b0;

  assign sdaIn = ~(sdaOe | otherPull);

  always #(CLK_PERIOD/2) clk = ~clk;

  arb_tx_unit i_arb_tx_unit (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .loadStb(loadStb),
    .loadByte(loadByte), .slaveEn(slaveEn), .lostClear(lostClear),
    .startDet(startDet), .sdaOe(sdaOe), .arbLost(arbLost),
    .byteDone(byteDone), .slaveRxReq(slaveRxReq)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // one byte against a competing master; other = competitor's bits
  task automatic runByte(input logic [7:0] mine, input logic [7:0] other,
                         input logic slv, input logic noise, input logic midLoad);
    logic lostExp = 1'b0;
    logic oeHold;
    slaveEn = slv;
    @(negedge clk); loadStb = 1'b1; loadByte = mine;
    @(negedge clk); loadStb = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      otherPull = noise ? 1'b1 : ~other[i];
      if (midLoad && i == 4) begin loadStb = 1'b1; loadByte = ~mine; end
      @(negedge clk); loadStb = 1'b0;
      @(negedge clk);
      otherPull = ~other[i];
      // R2 / R6 / R10: presented bit
      check(sdaOe == (!lostExp && !mine[i]), "R2/R6/R10 bit value", sdaOe, (!lostExp && !mine[i]));
      oeHold = sdaOe;
      sclIn = 1'b1;
      @(negedge clk);
      if (!lostExp && mine[i] && !other[i]) begin
        lostExp = 1'b1;
        stickyLost = 1'b1;
        if (slv) stickySlave = 1'b1;
      end
      check(arbLost == stickyLost, "R4/R5/R9 arbLost", arbLost, stickyLost);
      check(slaveRxReq == stickySlave, "R8 slaveRxReq", slaveRxReq, stickySlave);
      @(negedge clk);
      check(sdaOe == oeHold, "R3 oe stable while clock high", sdaOe, oeHold);
      sclIn = 1'b0;
      @(negedge clk);
      check(byteDone == (i == 0), "R7 byteDone timing", byteDone, (i == 0));
    end
    otherPull = 1'b0;
    @(negedge clk);
    check(byteDone == 1'b0, "R7 byteDone single cycle", byteDone, 0);
    check(sdaOe == 1'b0, "R6 released after byte", sdaOe, 0);
  endtask

  task automatic doClear(input logic useStart);
    @(negedge clk);
    if (useStart) startDet = 1'b1; else lostClear = 1'b1;
    @(negedge clk); startDet = 1'b0; lostClear = 1'b0;
    stickyLost = 1'b0; stickySlave = 1'b0;
    check(arbLost == 1'b0, "R9 arbLost cleared", arbLost, 0);
    check(slaveRxReq == 1'b0, "R9 slaveRxReq cleared", slaveRxReq, 0);
  endtask

  task automatic testReset();
    check(sdaOe == 0, "R1 sdaOe reset", sdaOe, 0);
    check(arbLost == 0, "R1 arbLost reset", arbLost, 0);
    check(byteDone == 0, "R1 byteDone reset", byteDone, 0);
    check(slaveRxReq == 0, "R1 slaveRxReq reset", slaveRxReq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    runByte(8'hA5, 8'hFF, 1'b0, 1'b0, 1'b0);  // R2: no competitor
    runByte(8'h3C, 8'h3C, 1'b1, 1'b0, 1'b0);  // same byte: no loss
    runByte(8'hFF, 8'h00, 1'b1, 1'b1, 1'b0);  // R5: low-phase noise, loses at MSB with slave
    runByte(8'h5A, 8'hFF, 1'b0, 1'b0, 1'b0);  // R9: flag sticky over next byte
    doClear(1'b0);
    runByte(8'hB7, 8'hB3, 1'b0, 1'b0, 1'b0);  // R4/R6/R8: loses at bit 2, no slave
    doClear(1'b1);
    runByte(8'h96, 8'h90, 1'b1, 1'b0, 1'b0);  // loses in data byte, slave request
    doClear(1'b0);
    runByte(8'h0F, 8'hFF, 1'b0, 1'b0, 1'b1);  // R10: load mid-byte ignored
    runByte(8'h00, 8'hFF, 1'b0, 1'b0, 1'b0);  // R5: own low drive never loses
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule